// File: doc/BRIEF.md
# I2C Interrupt Request Flag

This block produces the single interrupt request flag of a two-wire serial controller that can act as bus master or as addressed slave. It watches the serial clock and data lines and follows each transfer bit by bit. It finds start and stop conditions, counts clock pulses inside each byte, samples the acknowledge bit and spots an all-zero general call address. It combines these bus events with the controller's mode, its status inputs (arbitration lost, own address matched, start issued by this side) and its control bits to decide when an interrupt request is raised.

The flag is sticky. Software clears it with a one-cycle clear strobe, which stands for a write of zero to the flag. The wait enable bit moves the end-of-byte request from the rise of the ninth clock to the fall of the eighth clock. The acknowledge check bit adds a request when the receiver answers with a high acknowledge. Master and slave modes each have their own set of trigger conditions.

Both bus lines pass through a two-stage synchroniser before any edge is detected. A bus event therefore reaches the flag three clock cycles after the line changes.

Top module: `i2c_irq_flag`

## Requirements
- R1: After reset `irq_flag` is 0. Once set, it stays 1 until `clr_wr` is pulsed, and a pulse with no set condition clears it. When a set condition and `clr_wr` occur in the same cycle, the flag ends up 1.
- R2: A one-cycle `arb_lost` pulse sets the flag only when `mode_master`=1 and `al_ie`=1. With `al_ie`=0, or in slave mode, the pulse alone leaves the flag at 0.
- R3: In master mode, a start condition seen while `start_issued`=1 sets the flag. A start seen while `start_issued`=0 does not.
- R4: With `wait_en`=1 in master mode, the flag is set on the SCL falling edge that follows the 8th rising edge of a byte. It is not set at the 8th rise itself, nor at the 9th rise.
- R5: With `wait_en`=0 in master mode, the flag is set on the 9th SCL rising edge of each byte, and not on the fall of the 8th clock.
- R6: With `ack_chk_en`=1, a high SDA sampled at the 9th SCL rise sets the flag in either mode. With `ack_chk_en`=0, a high acknowledge has no effect.
- R7: In slave mode, if `addr_match`=1 at the 9th rise of the first byte after a start, the flag is set there. From then on it is also set at the end of every following byte (9th rise when `wait_en`=0), until the next start or stop.
- R8: In slave mode, a first byte of eight zero bits (general call, write direction) sets the flag at its 9th rise, and at the end of every following byte until the next start or stop. A first byte of 0x01 is not a general call.
- R9: In slave mode with no address match, no general call and no lost arbitration, bytes with a low acknowledge leave the flag at 0.
- R10: In slave mode, a stop condition sets the flag when `stop_mask`=0 and has no effect when `stop_mask`=1.
- R11: After an `arb_lost` pulse, the 9th rise of the first byte after a start (the received slave address) sets the flag. This memory of lost arbitration ends at the next stop.
- R12: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. Either one resets the clock count, so a repeated start in the middle of a byte restarts counting at bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Serial clock line level, asynchronous |
| sda_in | input | 1 | Serial data line level, asynchronous |
| mode_master | input | 1 | 1 = master mode, 0 = slave mode |
| start_issued | input | 1 | This controller has issued a start and is waiting for it on the bus |
| arb_lost | input | 1 | One-cycle pulse: bus arbitration lost |
| addr_match | input | 1 | Own slave address matched, valid at the 9th rise of the address byte |
| wait_en | input | 1 | Raise the end-of-byte request at the fall of the 8th clock |
| ack_chk_en | input | 1 | Raise a request on a high acknowledge bit |
| al_ie | input | 1 | Enable the request on arbitration lost |
| stop_mask | input | 1 | 1 = no request on stop in slave mode |
| clr_wr | input | 1 | One-cycle pulse: software writes 0 to the flag |
| irq_flag | output | 1 | Sticky interrupt request flag |

## Verification
Checks that run on every cycle cover the sticky flag: a set condition always leaves the flag high, a clear with no set drops it, and otherwise it holds. They also check that start and stop conditions return the bit count to zero and end the addressed-slave session. The per-mode trigger rules can only be shown by the bench's bus scenarios. These include which clock edge carries the end-of-byte request under each wait setting, masked versus unmasked stops, general call versus a near-miss address, and the address byte received after lost arbitration. They also include a repeated start mid-byte that must restart the count.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;

    parameter int unsigned DEF_FRAME_BITS  = 8;
    parameter int unsigned DEF_SYNC_STAGES = 2;

    // Synchronised line with its edges
    typedef struct packed {
        logic lvl;
        logic rise;
        logic fall;
    } line_t;

    // Bus events derived per cycle by the frame tracker
    typedef struct packed {
        logic start;
        logic stop;
        logic byte_fall;   // SCL fall after the last data bit
        logic ack_rise;    // SCL rise of the acknowledge clock
        logic ack_val;     // SDA at that rise
        logic addr_end;    // ack_rise of the first byte after a start
        logic gcall;       // first byte was all zero
    } frame_ev_t;

    typedef struct packed {
        logic wait_en;
        logic ack_chk_en;
        logic al_ie;
        logic stop_mask;
    } ctrl_t;

    function automatic logic byte_end_sel(input logic wait_en, input frame_ev_t ev);
        return wait_en ? ev.byte_fall : ev.ack_rise;
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                d,
    output i2c_irq_pkg::line_t  q
);
    logic [STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-1:0], d};
    end

    assign q.lvl  = chain[STAGES-1];
    assign q.rise = chain[STAGES-1] & ~chain[STAGES];
    assign q.fall = ~chain[STAGES-1] & chain[STAGES];
endmodule

// File: rtl/i2c_frame_track.sv
module i2c_frame_track #(
    parameter int unsigned FRAME_BITS = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  i2c_irq_pkg::line_t       scl,
    input  i2c_irq_pkg::line_t       sda,
    output i2c_irq_pkg::frame_ev_t   ev
);
    localparam int unsigned CNT_W = $clog2(FRAME_BITS + 2);
    localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(FRAME_BITS);
    localparam logic [CNT_W-1:0] ACK_CNT   = CNT_W'(FRAME_BITS + 1);

    logic [CNT_W-1:0] cnt;
    logic             first;
    logic             any_one;

    logic start_c, stop_c, ack_rise_c;
    assign start_c    = sda.fall & scl.lvl;
    assign stop_c     = sda.rise & scl.lvl;
    assign ack_rise_c = scl.rise & (cnt == LAST_DATA);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            first   <= 1'b0;
            any_one <= 1'b0;
        end else if (start_c || stop_c) begin
            cnt     <= '0;
            first   <= start_c;
            any_one <= 1'b0;
        end else if (scl.rise) begin
            cnt <= (cnt == ACK_CNT) ? CNT_W'(1) : cnt + CNT_W'(1);
            if (first && cnt < LAST_DATA) any_one <= any_one | sda.lvl;
            if (ack_rise_c) first <= 1'b0;
        end
    end

    assign ev.start     = start_c;
    assign ev.stop      = stop_c;
    assign ev.byte_fall = scl.fall & (cnt == LAST_DATA);
    assign ev.ack_rise  = ack_rise_c;
    assign ev.ack_val   = sda.lvl;
    assign ev.addr_end  = ack_rise_c & first;
    assign ev.gcall     = ack_rise_c & first & ~any_one;

    // R12: a start or stop returns the count to zero
    a_r12_cond_clears_cnt: assert property (@(posedge clk) disable iff (rst)
        (start_c || stop_c) |=> (cnt == '0));
endmodule

// File: rtl/i2c_irq_cond.sv
module i2c_irq_cond (
    input  logic                    clk,
    input  logic                    rst,
    input  i2c_irq_pkg::frame_ev_t  ev,
    input  i2c_irq_pkg::ctrl_t      ctl,
    input  logic                    mode_master,
    input  logic                    start_issued,
    input  logic                    arb_lost,
    input  logic                    addr_match,
    output logic                    set_req
);
    import i2c_irq_pkg::*;

    logic session;   // addressed slave (own address or general call)
    logic al_seen;   // arbitration lost since last stop
    logic byte_end, hit, set_m, set_s, set_any;

    assign byte_end = byte_end_sel(ctl.wait_en, ev);
    assign hit      = ev.addr_end & (addr_match | ev.gcall);

    assign set_m = (arb_lost & ctl.al_ie)
                 | (ev.start & start_issued)
                 | byte_end;
    assign set_s = (ev.stop & ~ctl.stop_mask)
                 | hit
                 | (session & byte_end);

    assign set_any = (mode_master ? set_m : set_s)
                   | (ctl.ack_chk_en & ev.ack_rise & ev.ack_val)
                   | (ev.addr_end & al_seen);

    always_ff @(posedge clk) begin
        if (rst) begin
            session <= 1'b0;
            al_seen <= 1'b0;
        end else begin
            if (ev.start || ev.stop)     session <= 1'b0;
            else if (!mode_master && hit) session <= 1'b1;
            if (arb_lost)     al_seen <= 1'b1;
            else if (ev.stop) al_seen <= 1'b0;
        end
    end

    assign set_req = set_any;

    // R7: the addressed session ends at a start or stop
    a_r7_session_ends: assert property (@(posedge clk) disable iff (rst)
        (ev.start || ev.stop) |=> !session);
    // R11: lost-arbitration memory ends at a stop
    a_r11_al_cleared_by_stop: assert property (@(posedge clk) disable iff (rst)
        (ev.stop && !arb_lost) |=> !al_seen);
endmodule

// File: rtl/i2c_irq_flag.sv
module i2c_irq_flag #(
    parameter int unsigned FRAME_BITS  = i2c_irq_pkg::DEF_FRAME_BITS,
    parameter int unsigned SYNC_STAGES = i2c_irq_pkg::DEF_SYNC_STAGES
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_in,
    input  logic sda_in,
    input  logic mode_master,
    input  logic start_issued,
    input  logic arb_lost,
    input  logic addr_match,
    input  logic wait_en,
    input  logic ack_chk_en,
    input  logic al_ie,
    input  logic stop_mask,
    input  logic clr_wr,
    output logic irq_flag
);
    import i2c_irq_pkg::*;

    localparam int unsigned NLINES = 2;

    logic  [NLINES-1:0] raw;
    line_t [NLINES-1:0] lines;
    frame_ev_t ev;
    ctrl_t     ctl;
    logic      set_req;

    assign raw = {sda_in, scl_in};

    for (genvar g = 0; g < NLINES; g++) begin : g_sync
        i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk(clk), .rst(rst), .d(raw[g]), .q(lines[g])
        );
    end

    i2c_frame_track #(.FRAME_BITS(FRAME_BITS)) u_track (
        .clk(clk), .rst(rst), .scl(lines[0]), .sda(lines[1]), .ev(ev)
    );

    assign ctl = '{wait_en: wait_en, ack_chk_en: ack_chk_en,
                   al_ie: al_ie, stop_mask: stop_mask};

    i2c_irq_cond u_cond (
        .clk(clk), .rst(rst), .ev(ev), .ctl(ctl),
        .mode_master(mode_master), .start_issued(start_issued),
        .arb_lost(arb_lost), .addr_match(addr_match), .set_req(set_req)
    );

    always_ff @(posedge clk) begin
        if (rst)          irq_flag <= 1'b0;
        else if (set_req) irq_flag <= 1'b1;
        else if (clr_wr)  irq_flag <= 1'b0;
    end

    // R1: set wins, clear drops, otherwise hold
    a_r1_set_wins: assert property (@(posedge clk) disable iff (rst)
        set_req |=> irq_flag);
    a_r1_clear: assert property (@(posedge clk) disable iff (rst)
        (clr_wr && !set_req) |=> !irq_flag);
    a_r1_hold: assert property (@(posedge clk) disable iff (rst)
        (!clr_wr && !set_req) |=> $stable(irq_flag));
endmodule

// File: tb/i2c_irq_flag_bench.sv
module i2c_irq_flag_bench;
    localparam int CLK_PERIOD = 10;
    localparam int PH = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_in = 1'b1, sda_in = 1'b1;
    logic mode_master = 1'b1, start_issued = 1'b0, arb_lost = 1'b0, addr_match = 1'b0;
    logic wait_en = 1'b0, ack_chk_en = 1'b0, al_ie = 1'b0, stop_mask = 1'b1, clr_wr = 1'b0;
    logic irq_flag;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_irq_flag u_i2c_irq_flag (
        .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
        .mode_master(mode_master), .start_issued(start_issued),
        .arb_lost(arb_lost), .addr_match(addr_match), .wait_en(wait_en),
        .ack_chk_en(ack_chk_en), .al_ie(al_ie), .stop_mask(stop_mask),
        .clr_wr(clr_wr), .irq_flag(irq_flag)
    );

    typedef struct { bit exp; string tag; } item_t;
    item_t q[$];
    int total = 0, bad = 0;
    bit done = 0;

    // Monitor: compare queued expectations with the flag
    always @(negedge clk) begin
        while (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            total++;
            if (irq_flag !== it.exp) begin
                bad++;
                $display("FAIL %s: irq_flag=%0b expected=%0b", it.tag, irq_flag, it.exp);
            end
        end
    end

    task automatic ph();
        repeat (PH) @(negedge clk);
    endtask
    task automatic chk(bit e, string tag);
        q.push_back('{e, tag});
        repeat (2) @(negedge clk);
    endtask
    task automatic bit_out(bit b);
        sda_in = b; ph(); scl_in = 1'b1; ph(); scl_in = 1'b0; ph();
    endtask
    task automatic byte_out(logic [7:0] v);
        for (int i = 7; i >= 0; i--) bit_out(v[i]);
    endtask
    // ninth clock with a check while SCL is high
    task automatic ack_chk(bit b, bit e, string tag);
        sda_in = b; ph(); scl_in = 1'b1; ph(); chk(e, tag); scl_in = 1'b0; ph();
    endtask
    task automatic bus_start();
        sda_in = 1'b0; ph(); scl_in = 1'b0; ph();
    endtask
    task automatic bus_rstart();
        sda_in = 1'b1; ph(); scl_in = 1'b1; ph(); sda_in = 1'b0; ph(); scl_in = 1'b0; ph();
    endtask
    task automatic bus_stop();
        sda_in = 1'b0; ph(); scl_in = 1'b1; ph(); sda_in = 1'b1; ph();
    endtask
    task automatic pulse_al();
        arb_lost = 1'b1; @(negedge clk); arb_lost = 1'b0; ph();
    endtask
    task automatic pulse_clr();
        clr_wr = 1'b1; @(negedge clk); clr_wr = 1'b0; ph();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        ph();
        chk(0, "R1 reset");

        // R2: arbitration lost in master mode
        al_ie = 1'b0; pulse_al(); chk(0, "R2 al_ie=0");
        al_ie = 1'b1; pulse_al(); chk(1, "R2 al_ie=1");
        ph(); chk(1, "R1 sticky");
        pulse_clr(); chk(0, "R1 clear");
        arb_lost = 1'b1; clr_wr = 1'b1; @(negedge clk);
        arb_lost = 1'b0; clr_wr = 1'b0; ph();
        chk(1, "R1 set wins over clear");
        pulse_clr(); al_ie = 1'b0;
        bus_start(); bus_stop(); chk(0, "R3 start without issue");

        // R3: start seen after issue
        start_issued = 1'b1; bus_start(); chk(1, "R3 start issued");
        start_issued = 1'b0; pulse_clr();

        // R5: no wait, 9th rise
        byte_out(8'h55); chk(0, "R5 no set at 8th fall");
        ack_chk(0, 1, "R5 9th rise");
        pulse_clr();

        // R4: wait, 8th fall
        wait_en = 1'b1;
        for (int i = 0; i < 7; i++) bit_out(i[0]);
        sda_in = 1'b1; ph(); scl_in = 1'b1; ph(); chk(0, "R4 not at 8th rise");
        scl_in = 1'b0; ph(); chk(1, "R4 8th fall");
        pulse_clr();
        ack_chk(0, 0, "R4 not at 9th rise");
        bus_stop(); wait_en = 1'b0;

        // R6, R9, R10: slave, not addressed
        mode_master = 1'b0; ack_chk_en = 1'b1;
        bus_start(); byte_out(8'hA5); ack_chk(1, 1, "R6 high ack checked");
        pulse_clr(); ack_chk_en = 1'b0;
        byte_out(8'h3C); ack_chk(1, 0, "R6 high ack unchecked");
        byte_out(8'hFF); ack_chk(0, 0, "R9 unaddressed byte");
        bus_stop(); chk(0, "R10 stop masked");
        stop_mask = 1'b0; bus_start(); bus_stop(); chk(1, "R10 stop unmasked");
        pulse_clr(); stop_mask = 1'b1;

        // R7: own address
        addr_match = 1'b1; bus_start(); byte_out(8'hA4);
        ack_chk(0, 1, "R7 address byte");
        pulse_clr(); addr_match = 1'b0;
        byte_out(8'h12); chk(0, "R7 mid byte");
        ack_chk(0, 1, "R7 data byte");
        pulse_clr();
        bus_rstart(); chk(0, "R7 repeated start");
        byte_out(8'h77); ack_chk(0, 0, "R9 session over");
        bus_stop();

        // R8: general call
        bus_start(); byte_out(8'h00); ack_chk(0, 1, "R8 general call");
        pulse_clr();
        byte_out(8'h5A); ack_chk(0, 1, "R8 gc data byte");
        pulse_clr(); bus_stop();
        bus_start(); byte_out(8'h01); ack_chk(0, 0, "R8 read bit not gc");
        bus_stop();

        // R11: address after arbitration lost
        bus_start(); bit_out(1); bit_out(0); bit_out(1);
        pulse_al(); chk(0, "R2 slave mode ignores al");
        for (int i = 0; i < 5; i++) bit_out(1);
        ack_chk(0, 1, "R11 address after al");
        pulse_clr(); bus_stop();
        bus_start(); byte_out(8'hB2); ack_chk(0, 0, "R11 cleared by stop");
        bus_stop();

        // R12: repeated start mid-byte restarts count
        mode_master = 1'b1;
        bus_start(); for (int i = 0; i < 5; i++) bit_out(1);
        bus_rstart(); chk(0, "R3 rstart without issue");
        byte_out(8'h81); chk(0, "R12 count restarted");
        ack_chk(0, 1, "R12 9th rise after rstart");
        pulse_clr(); bus_stop();

        repeat (10) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog: run did not complete");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule